// File: doc/BRIEF.md
# NAND Command and Address Front End

This block is the front end of a small-page NAND memory model. It sits behind the multiplexed 8-bit bus and its strobes (chip enable, command latch, address latch, write strobe, read strobe, write protect). All of these are sampled on a system clock. Each rising write strobe taken while chip enable is low is classed as a command, an address byte or a data byte. Address bytes are gathered into a 10-bit column and a 15-bit row (page) address. A column pointer moves over the two 256-byte halves of the page and the 16-byte spare tail. A state machine tracks the operation in progress, drives ready/busy and filters commands during busy periods.

The storage array and the real programme/erase timing are not part of the block. A busy counter stands in for them, loaded from one of three parameters (page read, programme, erase). Downstream logic sees the current column and row, a read-source code that says what a read strobe would return, and a status byte.

Top module: `nand_fe_top`

States:
- ST_IDLE: no operation is open.
- ST_RD_ADDR: gathering read address cycles.
- ST_PG_ADDR: gathering programme address cycles.
- ST_PG_DATA: accepting programme data until the confirm.
- ST_ER_ADDR: gathering the two erase row cycles until the confirm.
- ST_BUSY_RD, ST_BUSY_PG, ST_BUSY_ER: the busy countdown is running.
- ST_RD_DATA: the page is available to read.

Transitions:
- Pointer command (00h, 01h, 50h): ready state to ST_RD_ADDR.
- 80h: to ST_PG_ADDR.
- 60h: to ST_ER_ADDR.
- Third read address cycle: ST_RD_ADDR to ST_BUSY_RD.
- Third programme address cycle: ST_PG_ADDR to ST_PG_DATA.
- 10h with write protect high: ST_PG_DATA to ST_BUSY_PG.
- D0h after two erase row cycles with write protect high: ST_ER_ADDR to ST_BUSY_ER.
- Countdown expiry: ST_BUSY_RD to ST_RD_DATA; ST_BUSY_PG and ST_BUSY_ER to ST_IDLE.
- FFh: any state to ST_IDLE.
- Aborted programme or erase, or an undefined command: to ST_IDLE.

## Requirements
- R1: A command byte is taken on a rising write strobe when command latch is high, address latch is low and chip enable is low. A strobe with chip enable high has no effect.
- R2: Row bits [7:0] come from address cycle 2. Row bits [14:8] come from bits [6:0] of address cycle 3. Bit 7 of cycle 3 is ignored.
- R3: Address cycle 1 sets the column according to the region last chosen by a pointer command. 00h gives column = byte. 01h gives column = 256 + byte. 50h gives column = 512 + byte[3:0].
- R4: The second-half region stays in force until the third address cycle of a read or programme. After that cycle the region returns to the first half, so a later 80h with no pointer command addresses columns 0–255.
- R5: In ST_RD_DATA each falling read strobe with chip enable low advances the column by one. In ST_PG_DATA each data byte does the same. The column saturates at 527.
- R6: Address cycles beyond those an operation needs are ignored. This covers cycles after the third for read and programme, and after the second for erase.
- R7: Erase uses two row cycles: cycle 1 gives row[7:0] and cycle 2 gives row[14:8]. It leaves the column unchanged. D0h then starts the erase countdown.
- R8: Ready/busy (`rb_n`) goes low on the cycle an operation starts. It stays low for exactly T_READ, T_PROG or T_ERASE clock cycles. When a read completes, `rd_src` becomes 1 (array).
- R9: While busy, only FFh and 70h take effect. Every other command, and all address and data bytes, leave column, row and read source unchanged.
- R10: A programme or erase confirm given while write protect is low starts no countdown and sets status bit 0 (fail). 80h and 60h clear that bit.
- R11: In ST_PG_ADDR, ST_PG_DATA or ST_ER_ADDR, any command other than the valid confirm, 70h or FFh sets the fail bit and returns to ST_IDLE with `rd_src` = 0.
- R12: An undefined command returns to ST_IDLE with `rd_src` = 0. Data and address bytes are then ignored until a valid command arrives.
- R13: FFh, at any time, returns to ST_IDLE, makes the block ready, sets column to 0, region to first half, `rd_src` to 0 and fail to 0. Row is kept. The reset input gives the same state with row 0.
- R14: 70h sets `rd_src` = 3 (status) and leaves the state unchanged. 90h sets `rd_src` = 2 (identifier). `status` = {wp_n, rb_n, 5'b0, fail}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe; its rising edge latches the bus |
| re_n | input | 1 | Read strobe; its falling edge steps the column |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Multiplexed command/address/data bus |
| rb_n | output | 1 | Ready (1) or busy (0) |
| col_addr | output | 10 | Current column pointer |
| row_addr | output | 15 | Current row (page) address |
| rd_src | output | 2 | What a read returns: 0 none, 1 array, 2 identifier, 3 status |
| status | output | 8 | Status byte {wp_n, rb_n, 5'b0, fail} |

## Verification
The assertions assume the bus obeys the strobe protocol. Command latch and address latch are never high together on a write edge. Each strobe stays low and then high for at least one clock. The bench keeps to this by driving every byte through a single three-cycle task that raises the strobe while the latch signals are still steady. It drives read pulses only while write is idle. FFh or 70h may arrive on the very cycle a countdown expires; the assertions take no position on that case, and the stimulus keeps such commands well inside the busy window.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

    localparam int COL_W      = 10;
    localparam int ROW_W      = 15;
    localparam int BYTE_W     = 8;
    localparam int HALF_COLS  = 256;
    localparam int SPARE_BASE = 512;
    localparam int SPARE_COLS = 16;
    localparam int LAST_COL   = SPARE_BASE + SPARE_COLS - 1;
    localparam int SPARE_IDX_W = $clog2(SPARE_COLS);

    localparam logic [BYTE_W-1:0] OP_PTR_LOW   = 8'h00;
    localparam logic [BYTE_W-1:0] OP_PTR_HIGH  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_PTR_SPARE = 8'h50;
    localparam logic [BYTE_W-1:0] OP_PROG_OPEN = 8'h80;
    localparam logic [BYTE_W-1:0] OP_PROG_GO   = 8'h10;
    localparam logic [BYTE_W-1:0] OP_ERASE_OPEN = 8'h60;
    localparam logic [BYTE_W-1:0] OP_ERASE_GO  = 8'hD0;
    localparam logic [BYTE_W-1:0] OP_IDENT     = 8'h90;
    localparam logic [BYTE_W-1:0] OP_STATUS    = 8'h70;
    localparam logic [BYTE_W-1:0] OP_RESET     = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_PG_ADDR,
        ST_PG_DATA,
        ST_ER_ADDR,
        ST_BUSY_RD,
        ST_BUSY_PG,
        ST_BUSY_ER,
        ST_RD_DATA
    } fe_state_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_IDENT  = 2'd2,
        SRC_STATUS = 2'd3
    } rd_src_e;

    typedef enum logic [1:0] {
        REG_FIRST,
        REG_SECOND,
        REG_SPARE
    } col_region_e;

    typedef struct packed {
        logic              cmd;
        logic              addr;
        logic              data;
        logic              rd_step;
        logic [BYTE_W-1:0] val;
    } bus_ev_t;

endpackage

// File: rtl/nand_fe_strobe.sv
module nand_fe_strobe
    import nand_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              we_n,
    input  logic              re_n,
    input  logic [BYTE_W-1:0] io_in,
    output bus_ev_t           ev
);

    logic we_q;
    logic re_q;
    logic we_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    assign we_rise = !we_q && we_n && !ce_n;

    always_comb begin
        ev.cmd     = we_rise && cle && !ale;
        ev.addr    = we_rise && ale && !cle;
        ev.data    = we_rise && !cle && !ale;
        ev.rd_step = re_q && !re_n && !ce_n;
        ev.val     = io_in;
    end

endmodule

// File: rtl/nand_fe_busy.sv
module nand_fe_busy #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/nand_fe_colptr.sv
module nand_fe_colptr
    import nand_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              region_set,
    input  col_region_e       region_val,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              step,
    input  logic              revert,
    output logic [COL_W-1:0]  col,
    output col_region_e       region
);

    logic [COL_W-1:0] load_col;

    always_comb begin
        unique case (region)
            REG_SECOND: load_col = COL_W'(HALF_COLS) + COL_W'(load_byte);
            REG_SPARE:  load_col = COL_W'(SPARE_BASE) + COL_W'(load_byte[SPARE_IDX_W-1:0]);
            default:    load_col = COL_W'(load_byte);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region <= REG_FIRST;
            col    <= '0;
        end else begin
            if (clear) begin
                region <= REG_FIRST;
            end else if (region_set) begin
                region <= region_val;
            end else if (revert && region == REG_SECOND) begin
                region <= REG_FIRST;
            end

            if (clear) begin
                col <= '0;
            end else if (load) begin
                col <= load_col;
            end else if (step && col != COL_W'(LAST_COL)) begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nand_fe_top.sv
module nand_fe_top
    import nand_fe_pkg::*;
#(
    parameter int T_READ  = 600,
    parameter int T_PROG  = 2000,
    parameter int T_ERASE = 16000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              we_n,
    input  logic              re_n,
    input  logic              wp_n,
    input  logic [BYTE_W-1:0] io_in,
    output logic              rb_n,
    output logic [COL_W-1:0]  col_addr,
    output logic [ROW_W-1:0]  row_addr,
    output logic [1:0]        rd_src,
    output logic [BYTE_W-1:0] status
);

    localparam int T_MAX_RP = (T_READ > T_PROG) ? T_READ : T_PROG;
    localparam int T_MAX    = (T_MAX_RP > T_ERASE) ? T_MAX_RP : T_ERASE;
    localparam int CNT_W    = $clog2(T_MAX + 1);
    localparam int LO_W     = BYTE_W;
    localparam int HI_W     = ROW_W - BYTE_W;

    fe_state_e   state, nxt;
    bus_ev_t     ev;
    logic [1:0]  addr_cnt;
    logic [ROW_W-1:0] row_q;
    logic        fail_q;
    rd_src_e     src_q;
    logic        cmd_seen;

    // control strobes produced by the next-state logic
    logic        busy_load, busy_clr, busy_done;
    logic [CNT_W-1:0] busy_val, busy_cnt;
    logic        reg_set, col_load, col_step, col_revert, col_clr;
    col_region_e reg_val, region;
    logic        row_lo_we, row_hi_we, cnt_rst, cnt_inc;
    logic        fail_set, fail_clr, src_set;
    rd_src_e     src_val;
    logic        is_busy, pend_op;

    nand_fe_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .cle   (cle),
        .ale   (ale),
        .we_n  (we_n),
        .re_n  (re_n),
        .io_in (io_in),
        .ev    (ev)
    );

    nand_fe_busy #(.CNT_W(CNT_W)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (busy_clr),
        .load     (busy_load),
        .load_val (busy_val),
        .cnt      (busy_cnt),
        .done     (busy_done)
    );

    nand_fe_colptr u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (col_clr),
        .region_set (reg_set),
        .region_val (reg_val),
        .load       (col_load),
        .load_byte  (ev.val),
        .step       (col_step),
        .revert     (col_revert),
        .col        (col_addr),
        .region     (region)
    );

    assign cmd_seen = ev.cmd;
    assign is_busy  = (state == ST_BUSY_RD) || (state == ST_BUSY_PG) || (state == ST_BUSY_ER);
    assign pend_op  = (state == ST_PG_ADDR) || (state == ST_PG_DATA) || (state == ST_ER_ADDR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and control
    always_comb begin
        nxt        = state;
        busy_load  = 1'b0;
        busy_clr   = 1'b0;
        busy_val   = '0;
        reg_set    = 1'b0;
        reg_val    = REG_FIRST;
        col_load   = 1'b0;
        col_step   = 1'b0;
        col_revert = 1'b0;
        col_clr    = 1'b0;
        row_lo_we  = 1'b0;
        row_hi_we  = 1'b0;
        cnt_rst    = 1'b0;
        cnt_inc    = 1'b0;
        fail_set   = 1'b0;
        fail_clr   = 1'b0;
        src_set    = 1'b0;
        src_val    = SRC_NONE;

        // countdown expiry
        if (is_busy && busy_done) begin
            if (state == ST_BUSY_RD) begin
                nxt     = ST_RD_DATA;
                src_set = 1'b1;
                src_val = SRC_ARRAY;
            end else begin
                nxt = ST_IDLE;
            end
        end

        if (ev.cmd) begin
            if (ev.val == OP_RESET) begin
                nxt      = ST_IDLE;
                busy_clr = 1'b1;
                col_clr  = 1'b1;
                fail_clr = 1'b1;
                src_set  = 1'b1;
                src_val  = SRC_NONE;
            end else if (ev.val == OP_STATUS) begin
                src_set = 1'b1;
                src_val = SRC_STATUS;
            end else if (is_busy) begin
                nxt = state;
                if (busy_done) begin
                    nxt = (state == ST_BUSY_RD) ? ST_RD_DATA : ST_IDLE;
                end
            end else if (pend_op) begin
                if (state == ST_PG_DATA && ev.val == OP_PROG_GO) begin
                    if (wp_n) begin
                        nxt       = ST_BUSY_PG;
                        busy_load = 1'b1;
                        busy_val  = CNT_W'(T_PROG);
                    end else begin
                        nxt      = ST_IDLE;
                        fail_set = 1'b1;
                    end
                end else if (state == ST_ER_ADDR && ev.val == OP_ERASE_GO && addr_cnt == 2'd2) begin
                    if (wp_n) begin
                        nxt       = ST_BUSY_ER;
                        busy_load = 1'b1;
                        busy_val  = CNT_W'(T_ERASE);
                    end else begin
                        nxt      = ST_IDLE;
                        fail_set = 1'b1;
                    end
                end else begin
                    nxt      = ST_IDLE;
                    fail_set = 1'b1;
                    src_set  = 1'b1;
                    src_val  = SRC_NONE;
                end
            end else begin
                src_set = 1'b1;
                src_val = SRC_NONE;
                cnt_rst = 1'b1;
                unique case (ev.val)
                    OP_PTR_LOW: begin
                        nxt = ST_RD_ADDR; reg_set = 1'b1; reg_val = REG_FIRST;
                    end
                    OP_PTR_HIGH: begin
                        nxt = ST_RD_ADDR; reg_set = 1'b1; reg_val = REG_SECOND;
                    end
                    OP_PTR_SPARE: begin
                        nxt = ST_RD_ADDR; reg_set = 1'b1; reg_val = REG_SPARE;
                    end
                    OP_PROG_OPEN: begin
                        nxt = ST_PG_ADDR; fail_clr = 1'b1;
                    end
                    OP_ERASE_OPEN: begin
                        nxt = ST_ER_ADDR; fail_clr = 1'b1;
                    end
                    OP_IDENT: begin
                        nxt = ST_IDLE; src_val = SRC_IDENT;
                    end
                    default: begin
                        nxt = ST_IDLE;
                    end
                endcase
            end
        end else if (ev.addr) begin
            if (state == ST_RD_ADDR || state == ST_PG_ADDR) begin
                cnt_inc = 1'b1;
                unique case (addr_cnt)
                    2'd0: col_load  = 1'b1;
                    2'd1: row_lo_we = 1'b1;
                    default: begin
                        row_hi_we  = 1'b1;
                        col_revert = 1'b1;
                        if (state == ST_RD_ADDR) begin
                            nxt       = ST_BUSY_RD;
                            busy_load = 1'b1;
                            busy_val  = CNT_W'(T_READ);
                        end else begin
                            nxt = ST_PG_DATA;
                        end
                    end
                endcase
            end else if (state == ST_ER_ADDR && addr_cnt < 2'd2) begin
                cnt_inc   = 1'b1;
                row_lo_we = (addr_cnt == 2'd0);
                row_hi_we = (addr_cnt == 2'd1);
            end
        end else if (ev.data) begin
            col_step = (state == ST_PG_DATA);
        end else if (ev.rd_step) begin
            col_step = (state == ST_RD_DATA);
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_cnt <= '0;
            row_q    <= '0;
            fail_q   <= 1'b0;
            src_q    <= SRC_NONE;
        end else begin
            if (cnt_rst) begin
                addr_cnt <= '0;
            end else if (cnt_inc) begin
                addr_cnt <= addr_cnt + 1'b1;
            end
            if (row_lo_we) begin
                row_q[LO_W-1:0] <= ev.val;
            end
            if (row_hi_we) begin
                row_q[ROW_W-1:LO_W] <= ev.val[HI_W-1:0];
            end
            if (fail_set) begin
                fail_q <= 1'b1;
            end else if (fail_clr) begin
                fail_q <= 1'b0;
            end
            if (src_set) begin
                src_q <= src_val;
            end
        end
    end

    // outputs
    always_comb begin
        rb_n     = !is_busy;
        row_addr = row_q;
        rd_src   = src_q;
        status   = {wp_n, !is_busy, 5'b0, fail_q};
    end

endmodule

// File: rtl/nand_fe_chk.sv
module nand_fe_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wp_n,
    input logic [7:0]       io_in,
    input logic             cmd_seen,
    input logic [CNT_W-1:0] busy_cnt,
    input logic             rb_n,
    input logic [9:0]       col_addr,
    input logic [14:0]      row_addr,
    input logic [1:0]       rd_src,
    input logic [7:0]       status
);

    // R5
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_addr <= 10'd527);

    // R8
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_n |-> (busy_cnt != '0));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_n && !(cmd_seen && io_in == 8'hFF)) |=> ($stable(row_addr) && $stable(col_addr)));

    // R13
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_seen && io_in == 8'hFF) |=> (rb_n && rd_src == 2'd0 && !status[0]));

    // R10
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_seen && !wp_n && rb_n && (io_in == 8'h10 || io_in == 8'hD0)) |=> rb_n);

    // R14
    status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_seen && io_in == 8'h70) |=> (rd_src == 2'd3));

endmodule

bind nand_fe_top nand_fe_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .io_in    (io_in),
    .cmd_seen (cmd_seen),
    .busy_cnt (busy_cnt),
    .rb_n     (rb_n),
    .col_addr (col_addr),
    .row_addr (row_addr),
    .rd_src   (rd_src),
    .status   (status)
);

// File: tb/nand_fe_top_tb_top.sv
module nand_fe_top_tb_top;

    localparam int TR = 8;
    localparam int TP = 10;
    localparam int TE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic rb_n;
    logic [9:0] col_addr;
    logic [14:0] row_addr;
    logic [1:0] rd_src;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    nand_fe_top #(.T_READ(TR), .T_PROG(TP), .T_ERASE(TE)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
        .rb_n(rb_n), .col_addr(col_addr), .row_addr(row_addr),
        .rd_src(rd_src), .status(status)
    );

    // behavioural reference: modes 0 idle,1 read addr,2 prog addr,3 prog data,
    // 4 erase addr,5 busy read,6 busy prog,7 busy erase,8 read data
    int m_mode, m_col, m_row, m_part, m_acnt, m_fail, m_src, m_left;
    int p_we, p_re;

    function automatic int bump(int c);
        return (c < 527) ? c + 1 : c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_col = 0; m_row = 0; m_part = 0; m_acnt = 0;
            m_fail = 0; m_src = 0; m_left = 0; p_we = 1; p_re = 1;
        end else begin
            int s0;
            bit rise, fall, was_busy;
            int b;
            rise = (p_we == 0) && we_n && !ce_n;
            fall = (p_re == 1) && !re_n && !ce_n;
            p_we = we_n; p_re = re_n;
            s0 = m_mode;
            b = io_in;
            was_busy = (s0 >= 5 && s0 <= 7);
            if (was_busy) begin
                m_left--;
                if (m_left == 0) begin
                    if (s0 == 5) begin m_mode = 8; m_src = 1; end
                    else m_mode = 0;
                end
            end
            if (rise && cle && !ale) begin
                if (b == 'hFF) begin
                    m_mode = 0; m_left = 0; m_col = 0; m_part = 0; m_fail = 0; m_src = 0;
                end else if (b == 'h70) begin
                    m_src = 3;
                end else if (was_busy) begin
                end else if (s0 == 2 || s0 == 3 || s0 == 4) begin
                    if (s0 == 3 && b == 'h10) begin
                        if (wp_n) begin m_mode = 6; m_left = TP; end
                        else begin m_mode = 0; m_fail = 1; end
                    end else if (s0 == 4 && b == 'hD0 && m_acnt == 2) begin
                        if (wp_n) begin m_mode = 7; m_left = TE; end
                        else begin m_mode = 0; m_fail = 1; end
                    end else begin
                        m_mode = 0; m_fail = 1; m_src = 0;
                    end
                end else begin
                    m_src = 0; m_acnt = 0;
                    case (b)
                        'h00: begin m_mode = 1; m_part = 0; end
                        'h01: begin m_mode = 1; m_part = 1; end
                        'h50: begin m_mode = 1; m_part = 2; end
                        'h80: begin m_mode = 2; m_fail = 0; end
                        'h60: begin m_mode = 4; m_fail = 0; end
                        'h90: begin m_mode = 0; m_src = 2; end
                        default: m_mode = 0;
                    endcase
                end
            end else if (rise && ale && !cle) begin
                if (s0 == 1 || s0 == 2) begin
                    if (m_acnt == 0) begin
                        if (m_part == 0) m_col = b;
                        else if (m_part == 1) m_col = 256 + b;
                        else m_col = 512 + (b % 16);
                    end else if (m_acnt == 1) begin
                        m_row = (m_row / 256) * 256 + b;
                    end else begin
                        m_row = (b % 128) * 256 + (m_row % 256);
                        if (m_part == 1) m_part = 0;
                        if (s0 == 1) begin m_mode = 5; m_left = TR; end
                        else m_mode = 3;
                    end
                    m_acnt++;
                end else if (s0 == 4 && m_acnt < 2) begin
                    if (m_acnt == 0) m_row = (m_row / 256) * 256 + b;
                    else m_row = (b % 128) * 256 + (m_row % 256);
                    m_acnt++;
                end
            end else if (rise && !cle && !ale) begin
                if (s0 == 3) m_col = bump(m_col);
            end else if (fall) begin
                if (s0 == 8) m_col = bump(m_col);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            int eb;
            eb = (m_mode >= 5 && m_mode <= 7) ? 0 : 1;
            check(rb_n == eb, "R8", "model rb_n", rb_n, eb);
            check(col_addr == m_col, "R3", "model col", col_addr, m_col);
            check(row_addr == m_row, "R2", "model row", row_addr, m_row);
            check(rd_src == m_src, "R14", "model rd_src", rd_src, m_src);
            check(status == {wp_n, eb[0], 5'b0, m_fail[0]}, "R10", "model status",
                  status, {wp_n, eb[0], 5'b0, m_fail[0]});
        end
    end

    task automatic strobe(input bit c, input bit a, input logic [7:0] v);
        @(negedge clk); #1; cle = c; ale = a; io_in = v; we_n = 1'b0;
        @(negedge clk); #1; we_n = 1'b1;
        @(negedge clk); #1; cle = 1'b0; ale = 1'b0;
    endtask
    task automatic cmd(input logic [7:0] v);  strobe(1'b1, 1'b0, v); endtask
    task automatic adr(input logic [7:0] v);  strobe(1'b0, 1'b1, v); endtask
    task automatic dat(input logic [7:0] v);  strobe(1'b0, 1'b0, v); endtask
    task automatic rd_pulse();
        @(negedge clk); #1; re_n = 1'b0;
        @(negedge clk); #1; re_n = 1'b1;
    endtask
    task automatic busy_len(output int n);
        n = 0;
        while (rb_n == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    initial begin
        #1600000;
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R13 reset state
        check(rb_n == 1 && col_addr == 0 && row_addr == 0 && rd_src == 0, "R13", "reset outputs",
              {rb_n, col_addr, row_addr, rd_src}, {1'b1, 27'd0});
        check(status == 8'hC0, "R13", "reset status", status, 8'hC0);

        // R1 chip enable gating
        cmd(8'h90);
        check(rd_src == 0, "R1", "cmd with ce_n high", rd_src, 0);
        ce_n = 1'b0;
        cmd(8'h90);
        check(rd_src == 2, "R1", "ident command", rd_src, 2);

        // R2 R3 first-half read
        cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'hB5);
        check(col_addr == 10'h012, "R3", "first half column", col_addr, 10'h012);
        check(row_addr == 15'h3534, "R2", "row with bit7 masked", row_addr, 15'h3534);
        busy_len(n);
        check(n == TR, "R8", "read busy length", n, TR);
        check(rd_src == 1, "R8", "array source after read", rd_src, 1);
        repeat (3) rd_pulse();
        check(col_addr == 10'h015, "R5", "read steps", col_addr, 10'h015);

        // R3 R4 second half and revert
        cmd(8'h01); adr(8'h20); adr(8'h00); adr(8'h00);
        check(col_addr == 10'h120, "R3", "second half column", col_addr, 10'h120);
        busy_len(n);
        cmd(8'h80); adr(8'h05); adr(8'h00); adr(8'h00);
        check(col_addr == 10'h005, "R4", "revert to first half", col_addr, 10'h005);
        cmd(8'hFF);
        cmd(8'h01); cmd(8'h80); adr(8'h05); adr(8'h01); adr(8'h00);
        check(col_addr == 10'h105, "R4", "second half held for program", col_addr, 10'h105);

        // R10 write protect
        wp_n = 1'b0;
        cmd(8'h10);
        check(rb_n == 1, "R10", "no busy under protect", rb_n, 1);
        check(status == 8'h41, "R10", "fail under protect", status, 8'h41);
        wp_n = 1'b1;

        // R3 R5 spare region and saturation
        cmd(8'h50); adr(8'h3A); adr(8'h00); adr(8'h00);
        check(col_addr == 10'd522, "R3", "spare column", col_addr, 522);
        busy_len(n);
        repeat (7) rd_pulse();
        check(col_addr == 10'd527, "R5", "saturate at spare end", col_addr, 527);

        // R6 extra address cycles
        cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03);
        adr(8'h77);
        check(row_addr == 15'h0302, "R6", "extra read address", row_addr, 15'h0302);
        busy_len(n);
        cmd(8'h80); adr(8'h10); adr(8'h20); adr(8'h30); adr(8'h44);
        check(col_addr == 10'h010 && row_addr == 15'h3020, "R6", "extra program address",
              {col_addr, row_addr}, {10'h010, 15'h3020});
        dat(8'hAA); dat(8'hBB);
        check(col_addr == 10'h012, "R5", "program data steps", col_addr, 10'h012);
        cmd(8'h10);
        busy_len(n);
        check(n == TP, "R8", "program busy length", n, TP);

        // R11 missing confirm
        cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00);
        cmd(8'h60);
        check(status == 8'hC1 && rd_src == 0, "R11", "abort sets fail", status, 8'hC1);
        dat(8'h5A);
        check(col_addr == 10'h000, "R12", "data ignored when idle", col_addr, 0);

        // R7 erase
        cmd(8'h60); adr(8'h11); adr(8'h92); adr(8'h55);
        check(row_addr == 15'h1211 && col_addr == 10'h000, "R7", "erase rows",
              {col_addr, row_addr}, {10'h000, 15'h1211});
        check(status[0] == 1'b0, "R10", "fail cleared by 60h", status[0], 0);
        cmd(8'hD0);
        busy_len(n);
        check(n == TE, "R7", "erase busy length", n, TE);

        // R9 R13 R14 busy filtering
        cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'hD0);
        cmd(8'h00);
        check(rb_n == 0 && rd_src == 0, "R9", "command ignored while busy", {rb_n, rd_src}, 0);
        cmd(8'h70);
        check(rd_src == 3 && status == 8'h80, "R14", "status while busy", {rd_src, status}, {2'd3, 8'h80});
        cmd(8'hFF);
        check(rb_n == 1 && rd_src == 0, "R13", "reset aborts busy", {rb_n, rd_src}, {1'b1, 2'd0});

        // R12 undefined command
        cmd(8'h33); adr(8'h55); dat(8'h66);
        check(rd_src == 0 && row_addr == 15'h0201 && col_addr == 0, "R12", "undefined command ignores bytes",
              row_addr, 15'h0201);

        // R14 status with protect low
        wp_n = 1'b0;
        cmd(8'h70);
        check(status == 8'h40 && rd_src == 3, "R14", "status byte layout", status, 8'h40);
        wp_n = 1'b1;

        repeat (3) @(negedge clk);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule